// File: doc/BRIEF.md
# Dot Inversion Output Hold and Polarity Stage

This block is the output-side half of a column driver's double-buffered line store. The input capture logic fills a separate bank with one 6-bit gray code per channel. A rising edge on the load strobe copies that whole bank into this block's output hold register. On the same edge, the block samples the polarity select.

Between load edges the held codes do not change, whatever the capture side does. Each channel carries a range flag next to its held code. Adjacent channels always get opposite flags, which gives dot inversion. The latched polarity decides which parity of channel takes the positive reference range.

A load may come at any time, even before the capture bank has been fully rewritten. In that case the block takes whatever the bank presents at that moment.

Top module: `dot_inv_load`

## Requirements
- R1: While reset is asserted, every held code is 0 and the latched polarity is 0. The range vector therefore reads 1 on bits 0, 2, 4, … and 0 on bits 1, 3, 5, ….
- R2: A low-to-high change of `ld` seen at a clock edge copies all of `line_in` into `code_out`, visible after that same edge. Channel i occupies bits [i*6-1 : (i-1)*6].
- R3: `pol` is sampled at the same clock edge as the transfer in R2 and held for the whole line.
- R4: With latched polarity 1, channels 2, 4, 6, … (range bits 1, 3, 5, …) read 1, meaning the positive range. Channels 1, 3, 5, … (bits 0, 2, 4, …) read 0, meaning the negative range. Bit i-1 belongs to channel i, and channel 1 counts as odd.
- R5: With latched polarity 0, the assignment in R4 is reversed: odd channels read 1 and even channels read 0.
- R6: While `ld` stays high after its rising edge, no further transfer or polarity sample takes place.
- R7: While `ld` stays low, `code_out` and `pos_range` keep their values, even when `line_in` and `pol` change.
- R8: A load taken after only part of the capture bank has been rewritten delivers the rewritten channels with their new codes. The other channels deliver whatever the bank still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load strobe; its rising edge transfers the line |
| pol | input | 1 | Polarity select, sampled on load |
| line_in | input | NUM_CH*CODE_W | Capture bank contents |
| code_out | output | NUM_CH*CODE_W | Held per-channel codes |
| pos_range | output | NUM_CH | Per-channel range select, 1 = positive range |

## Verification
The bench builds the block with its default parameters: 420 channels of 6-bit codes. This puts the full 2520-bit line and the parity of the last channel (channel 420, even) within reach of every check. Random lines and polarities are mixed with directed cases: all-ones codes, a partially rewritten bank, and a strobe held high while the inputs keep changing. Together these separate an edge-triggered load from a level-triggered one.

// File: rtl/dot_inv_load.sv
module dot_inv_load #(
  parameter int NUM_CH = 420,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic                     pol,
  input  logic [NUM_CH*CODE_W-1:0] line_in,
  output logic [NUM_CH*CODE_W-1:0] code_out,
  output logic [NUM_CH-1:0]        pos_range
);
  localparam int LINE_W = NUM_CH * CODE_W;

  logic              ld_q;
  logic              pol_q;
  logic [LINE_W-1:0] hold_q;
  logic              load;

  assign load = ld & ~ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      pol_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      ld_q <= ld;
      if (load) begin
        pol_q  <= pol;
        hold_q <= line_in;
      end
    end
  end

  assign code_out = hold_q;

  for (genvar j = 0; j < NUM_CH; j++) begin : g_rng
    if (j % 2 == 1) begin : g_even_ch
      assign pos_range[j] = pol_q;
    end else begin : g_odd_ch
      assign pos_range[j] = ~pol_q;
    end
  end
endmodule

module dot_inv_load_chk #(
  parameter int NUM_CH = 420,
  parameter int CODE_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ld,
  input logic                     pol,
  input logic [NUM_CH*CODE_W-1:0] line_in,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        pos_range
);
  logic prev_ld;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_ld <= 1'b0;
    else        prev_ld <= ld;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (code_out == '0 || !rst_n));

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !prev_ld) |=> code_out == $past(line_in));

  // R3
  pol_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !prev_ld) |=> pos_range[1] == $past(pol));

  // R4
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_range[0] != pos_range[1]);

  // R6
  held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && prev_ld) |=> $stable(code_out) && $stable(pos_range));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(code_out) && $stable(pos_range));
endmodule

bind dot_inv_load dot_inv_load_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .pol(pol), .line_in(line_in),
  .code_out(code_out), .pos_range(pos_range)
);

// File: tb/dot_inv_load_tb.sv
module dot_inv_load_tb;
  localparam int NUM_CH = 420;
  localparam int CODE_W = 6;
  localparam int LINE_W = NUM_CH * CODE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld = 1'b0;
  logic              pol = 1'b0;
  logic [LINE_W-1:0] line_in = '0;
  logic [LINE_W-1:0] code_out;
  logic [NUM_CH-1:0] pos_range;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dot_inv_load #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .pol(pol), .line_in(line_in),
    .code_out(code_out), .pos_range(pos_range)
  );

  function automatic logic [NUM_CH-1:0] exp_pos(input logic p);
    logic [NUM_CH-1:0] v;
    for (int j = 0; j < NUM_CH; j++) v[j] = (j % 2 == 1) ? p : ~p;
    return v;
  endfunction

  function automatic logic [LINE_W-1:0] rand_line();
    logic [LINE_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++) v[c*CODE_W +: CODE_W] = CODE_W'($urandom);
    return v;
  endfunction

  task automatic check_state(input logic [LINE_W-1:0] el, input logic ep, input string tag);
    checks++;
    if (code_out !== el) begin
      fails++;
      $display("FAIL %s codes: actual %h expected %h", tag, code_out, el);
    end
    checks++;
    if (pos_range !== exp_pos(ep)) begin
      fails++;
      $display("FAIL %s range: actual %h expected %h", tag, pos_range, exp_pos(ep));
    end
  endtask

  task automatic load_and_check(input logic [LINE_W-1:0] l, input logic p, input string tag);
    @(negedge clk);
    line_in = l; pol = p; ld = 1'b1;
    @(negedge clk);
    check_state(l, p, tag);
    line_in = rand_line(); pol = ~p;
    @(negedge clk);
    @(negedge clk);
    check_state(l, p, "R6 held high");
    ld = 1'b0;
    line_in = rand_line(); pol = $urandom;
    @(negedge clk);
    @(negedge clk);
    check_state(l, p, "R7 idle");
  endtask

  initial begin
    logic [LINE_W-1:0] cur;
    logic [LINE_W-1:0] part;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_state('0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state('0, 1'b0, "R1 after release");

    cur = '1;
    load_and_check(cur, 1'b1, "R2 R4 all ones pol1");
    load_and_check(cur, 1'b0, "R3 R5 pol0");
    for (int k = 0; k < 20; k++) begin
      cur = rand_line();
      load_and_check(cur, 1'($urandom), "R2 R3 random");
    end

    part = cur;
    for (int c = 0; c < 10; c++) part[c*CODE_W +: CODE_W] = CODE_W'($urandom);
    load_and_check(part, 1'b1, "R8 partial fill");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule